// File: doc/BRIEF.md
# Vector index conflict subset selector

The block accepts a vector of sixteen 32-bit lane indices and then splits the lanes into a series of passes. In each pass, no two issued lanes carry the same index. A lane issued in a pass can therefore take part in a gather, modify and scatter update in that pass, and no other lane in the same pass writes to the same memory location. The memory traffic and the arithmetic belong to the consumer, not to this block.

When a vector is loaded, every lane becomes pending. In each pass the block offers a subset of the pending lanes. A pending lane is admitted unless a lower-numbered pending lane has the same index. The consumer accepts the subset with a valid/ready handshake. The accepted subset is then removed from the pending mask by exclusive-OR. Passes repeat until the mask is empty. The block then pulses `done` and returns to idle, ready for the next vector.

The control is a two-state machine. In `ST_IDLE` the block waits for a vector. The transition *load* (`in_valid && in_ready`) moves it to `ST_ISSUE`. In `ST_ISSUE` a subset is offered every cycle. The transition *next pass* (accepted, lanes still pending) stays in `ST_ISSUE`. The transition *finish* (accepted, mask now empty) returns to `ST_IDLE`.

Top module: `vidx_subset_sel`

## Requirements
- R1: After reset, `in_ready` is 1, `sub_valid` is 0 and `done` is 0.
- R2: In `ST_IDLE`, a cycle with `in_valid` and `in_ready` both high captures `in_idx`, where lane i occupies bits [32*i+31:32*i]. It also sets all 16 pending bits. In the next cycle `sub_valid` is 1 and `in_ready` is 0.
- R3: Bit i of `sub_mask` is 1 exactly when lane i is pending and no lower-numbered pending lane has an index equal to it over all 32 bits.
- R4: When a pass is accepted (`sub_valid && sub_ready`), the pending mask becomes the old mask XOR `sub_mask`. An accepted lane is never offered again for the same vector.
- R5: While `sub_valid` is high and `sub_ready` is low, `sub_mask` and `sub_last` hold their values, and `sub_valid` stays high.
- R6: `sub_last` is 1 exactly when accepting the current subset would empty the pending mask. One cycle after that subset is accepted, `done` is 1 for a single cycle, `in_ready` is 1 and `sub_valid` is 0.
- R7: A lane that is no longer pending never blocks another lane, even when the two lanes have equal indices.
- R8: Over one vector, every lane is issued exactly once. The number of passes equals the largest count of lanes that share one index value.
- R9: `in_valid` is ignored while the block is in `ST_ISSUE`. The stored indices and the pending mask are not changed by it.
- R10: `sub_valid` never offers an empty subset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Index vector offered |
| in_ready | output | 1 | Block is idle and can accept a vector |
| in_idx | input | 512 | Sixteen 32-bit lane indices, lane 0 in the low bits |
| sub_valid | output | 1 | A conflict-free subset is offered |
| sub_ready | input | 1 | Consumer accepts the offered subset |
| sub_mask | output | 16 | Lanes admitted in this pass |
| sub_last | output | 1 | This pass empties the pending mask |
| done | output | 1 | One-cycle pulse after the final pass is accepted |

## Verification
The bench uses vectors with all indices distinct (one pass) and all indices equal (sixteen passes, one lane each). It also uses indices that differ only in the top bit, which catches a design that compares a truncated index and merges lanes that should be separate. Random vectors drawn from a small value range produce mixed duplicates. On these, a design that forgets to qualify the compare with the pending mask stalls lanes behind already-served partners and needs too many passes. Random back-pressure on `sub_ready` exposes a subset that changes while stalled. The bench also sends stray `in_valid` pulses during issue; a design that reloads on them produces the wrong masks.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } sel_state_e;
endpackage

// File: rtl/vsel_eq_matrix.sv
// Pairwise full-width equality of each lane against every lower lane.
module vsel_eq_matrix #(
    parameter int LANES = 16,
    parameter int IDX_W = 32
) (
    input  logic [LANES*IDX_W-1:0] idx,
    output logic [LANES*LANES-1:0] eq_lower
);
    for (genvar i = 0; i < LANES; i++) begin : g_row
        for (genvar j = 0; j < LANES; j++) begin : g_col
            if (j < i) begin : g_cmp
                assign eq_lower[i*LANES+j] =
                    (idx[i*IDX_W +: IDX_W] == idx[j*IDX_W +: IDX_W]);
            end else begin : g_zero
                assign eq_lower[i*LANES+j] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/vsel_pick.sv
// Admits the lowest pending lane of each index group.
module vsel_pick #(
    parameter int LANES = 16
) (
    input  logic [LANES*LANES-1:0] eq_lower,
    input  logic [LANES-1:0]       pending,
    output logic [LANES-1:0]       subset
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign subset[i] = pending[i] &
                           ~(|(eq_lower[i*LANES +: LANES] & pending));
    end
endmodule

// File: rtl/vidx_subset_sel.sv
module vidx_subset_sel #(
    parameter int LANES = 16,
    parameter int IDX_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*IDX_W-1:0] in_idx,
    output logic                   sub_valid,
    input  logic                   sub_ready,
    output logic [LANES-1:0]       sub_mask,
    output logic                   sub_last,
    output logic                   done
);
    import vsel_pkg::*;

    localparam int VEC_W = LANES * IDX_W;

    sel_state_e             state_q, state_d;
    logic [VEC_W-1:0]       idx_q;
    logic [LANES-1:0]       pend_q;
    logic [LANES-1:0]       subset;
    logic [LANES-1:0]       pend_next;
    logic [LANES*LANES-1:0] eq_lower;
    logic                   load, accept, done_q;

    vsel_eq_matrix #(.LANES(LANES), .IDX_W(IDX_W)) u_eq (
        .idx      (idx_q),
        .eq_lower (eq_lower)
    );

    vsel_pick #(.LANES(LANES)) u_pick (
        .eq_lower (eq_lower),
        .pending  (pend_q),
        .subset   (subset)
    );

    assign pend_next = pend_q ^ subset;

    // Output and next-state process
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        sub_valid = 1'b0;
        sub_mask  = '0;
        sub_last  = 1'b0;
        load      = 1'b0;
        accept    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    load    = 1'b1;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                sub_valid = 1'b1;
                sub_mask  = subset;
                sub_last  = (pend_next == '0);
                if (sub_ready) begin
                    accept = 1'b1;
                    if (pend_next == '0) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pend_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= accept && (pend_next == '0);
            if (load) begin
                idx_q  <= in_idx;
                pend_q <= '1;
            end else if (accept) begin
                pend_q <= pend_next;
            end
        end
    end

    assign done = done_q;
endmodule

// File: rtl/vsel_chk.sv
module vsel_chk #(
    parameter int LANES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             sub_valid,
    input logic             sub_ready,
    input logic [LANES-1:0] sub_mask,
    input logic             sub_last,
    input logic             done
);
    // R10
    nonempty_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> (sub_mask != '0));
    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_mask) && $stable(sub_last)));
    // R4
    no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && sub_ready && !sub_last) |=> (sub_valid && ((sub_mask & $past(sub_mask)) == '0)));
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (in_ready && !sub_valid));
    // R6
    last_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && sub_ready && sub_last) |=> done);
    // R2
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && sub_valid));
endmodule

bind vidx_subset_sel vsel_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_vidx_subset_sel.sv
module tb_vidx_subset_sel;
    localparam int L = 16;
    localparam int W = 32;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_ready, sub_valid, sub_ready = 0, sub_last, done;
    logic [L*W-1:0] in_idx = '0;
    logic [L-1:0] sub_mask;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    vidx_subset_sel dut (.*);

    function automatic logic [L-1:0] model(input logic [L*W-1:0] v, input logic [L-1:0] p);
        logic [L-1:0] r = '0;
        for (int i = 0; i < L; i++) begin
            logic blk = 1'b0;
            for (int j = 0; j < i; j++)
                if (p[j] && v[j*W +: W] == v[i*W +: W]) blk = 1'b1;
            r[i] = p[i] && !blk;
        end
        return r;
    endfunction

    function automatic int max_mult(input logic [L*W-1:0] v);
        int m = 0;
        for (int i = 0; i < L; i++) begin
            int c = 0;
            for (int j = 0; j < L; j++) if (v[j*W +: W] == v[i*W +: W]) c++;
            if (c > m) m = c;
        end
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [L*W-1:0] v, input bit stalls, input bit stray);
        logic [L-1:0] pend = '1, seen = '0, exp;
        int passes = 0;
        @(negedge clk);
        chk(in_ready, "R2 ready before load", in_ready, 1);
        in_valid = 1; in_idx = v;
        @(negedge clk);
        in_valid = 0;
        chk(sub_valid && !in_ready, "R2 issue after load", {in_ready, sub_valid}, 2'b01);
        while (pend != 0 && passes < 40) begin
            exp = model(v, pend);
            chk(sub_mask == exp, "R3 subset", sub_mask, exp);
            chk(sub_last == ((pend ^ exp) == 0), "R6 last flag", sub_last, (pend ^ exp) == 0);
            chk((sub_mask & seen) == 0, "R8 no lane twice", sub_mask & seen, 0);
            sub_ready = stalls ? ($urandom_range(0, 2) != 0) : 1'b1;
            if (stray) begin in_valid = 1; in_idx = ~v; end
            @(negedge clk);
            in_valid = 0;
            if (sub_ready) begin
                seen |= exp; pend ^= exp; passes++;
            end else begin
                chk(sub_valid && sub_mask == exp, "R5 stall hold", sub_mask, exp);
            end
            sub_ready = 0;
        end
        chk(done && in_ready && !sub_valid, "R6 done pulse", {done, in_ready, sub_valid}, 3'b110);
        chk(seen == '1, "R8 all lanes served", seen, 16'hffff);
        chk(passes == max_mult(v), "R8 pass count", passes, max_mult(v));
        @(negedge clk);
        chk(!done, "R6 done single cycle", done, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [L*W-1:0] v;
        void'($urandom(32'h5eed_1234));
        #1;
        chk(in_ready && !sub_valid && !done, "R1 reset state", {in_ready, sub_valid, done}, 3'b100);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(in_ready && !sub_valid && !done, "R1 after reset", {in_ready, sub_valid, done}, 3'b100);
        // all distinct: one pass
        for (int i = 0; i < L; i++) v[i*W +: W] = 32'(i * 7 + 3);
        run_vec(v, 0, 0);
        // all equal: sixteen passes; served lanes must not block (R7)
        for (int i = 0; i < L; i++) v[i*W +: W] = 32'hdead_beef;
        run_vec(v, 0, 0);
        // R3 full width: pairs differing only in bit 31
        for (int i = 0; i < L; i++) v[i*W +: W] = {i[0], 31'h55};
        run_vec(v, 1, 0);
        // R9 stray in_valid while issuing
        for (int i = 0; i < L; i++) v[i*W +: W] = 32'(i % 3);
        run_vec(v, 1, 1);
        // random vectors with small value range
        for (int k = 0; k < 40; k++) begin
            int rng = $urandom_range(1, 12);
            for (int i = 0; i < L; i++) v[i*W +: W] = 32'($urandom_range(0, rng));
            run_vec(v, 1, (k % 4) == 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule